// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Sequenced Processor Core

This block is a small accumulator-style processor. It has three working registers (A, B and C), a comparison flag register, a program counter, an instruction register and an operand register. It talks to one shared memory over an 8-bit address bus, which gives a 256-byte space. The port set has a read strobe, a write strobe, a write-data bus and a read-data bus. Code sits from address 0 upward, and data is normally placed at 128 and above. Reads are combinational: the memory returns the addressed byte in the same cycle as the read strobe, and the core latches it at the next rising edge.

A control sequencer walks every instruction through ordered steps. The steps are opcode fetch, decode, an optional operand-byte fetch, and execute. The program-counter increment is folded into each fetch step. A one-byte instruction therefore takes three clocks and a two-byte instruction takes four. Arithmetic results always land in C. A compare records unsigned equal, greater and less flags, which later conditional jumps consult. A stop instruction parks the core until reset.

Top module: `byte_seq_cpu`

## Requirements
- R1: While reset (synchronous, active low) is held and in the first cycle after it is released, the core drives address 0 with the read strobe high, the write strobe low and `halted` low. A, B, C, the flags and the program counter all reset to 0.
- R2: The opcodes are LDA=1, LDB=2, LDI=3, STB=4, STC=5, ADD=6, SUB=7, MUL=8, DIV=9, CMP=10, JMP=11, JEQ=12, JNE=13, JGT=14, JGE=15, JLT=16, JLE=17, HLT=18. Codes 1–5 and 11–17 carry a second byte. A one-byte instruction takes 3 clocks and advances the program counter by 1. A two-byte instruction takes 4 clocks and advances it by 2 when it does not branch.
- R3: LDA and LDB load A or B from memory at the operand address. LDI loads the operand byte itself into B.
- R4: STB and STC write B or C to the operand address with a write strobe that lasts exactly one cycle.
- R5: ADD, SUB and MUL put A+B, A−B and A×B (all modulo 256) into C. DIV puts the unsigned quotient A/B into C, or 255 when B is 0. None of these changes A or B.
- R6: CMP records whether A equals, is greater than or is less than B, compared unsigned. JMP always loads the program counter with the operand. JEQ, JNE, JGT, JGE, JLT and JLE jump only when equal, not equal, greater, greater-or-equal, less or less-or-equal holds for the last compare. After reset, before any compare, all three flags are clear.
- R7: HLT raises `halted` three clocks after its fetch begins. From then until reset, `halted` stays high and neither strobe is asserted.
- R8: Any opcode outside 1–18 (0 and 19–255) is a one-byte, three-clock no-operation.
- R9: A factorial program that loops a counter at address 128 from 1 to 5 and multiplies an accumulator at address 129 halts with 120 at 129 and 6 at 128.
- R10: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Memory address (program counter or operand) |
| mem_rd | output | 1 | Read strobe; data is taken from `mem_rdata` at the next edge |
| mem_wr | output | 1 | Write strobe; memory stores `mem_wdata` at the next edge |
| mem_wdata | output | 8 | Write data (B or C) |
| mem_rdata | input | 8 | Read data, valid in the cycle the read strobe is high |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
Every instruction finishes on a fixed edge: the third clock for one-byte codes and the fourth for two-byte codes. A store reaches memory on its last edge, and `halted` rises on the third edge of the stop instruction. The bench builds each straight-line program with emit tasks that add 3 or 4 clocks to an expected total. A taken jump subtracts the skipped pair of instructions. After releasing reset on a falling edge, the bench counts falling edges until `halted` is seen and compares that count with the total. All strobe and memory samples are taken on falling edges, half a period after the registers settle. Memory results are read only after halt, when no further write can be pending.

// File: rtl/cpu_pkg.sv
// Package: cpu_pkg
// Shared widths, opcode values, sequencer steps, ALU selects and the
// control bundle passed from the sequencer to the datapath.
// Assumes an 8-bit opcode byte; data width is a parameter default only.
package cpu_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [7:0] {
        OP_LDA = 8'd1,  OP_LDB = 8'd2,  OP_LDI = 8'd3,  OP_STB = 8'd4,
        OP_STC = 8'd5,  OP_ADD = 8'd6,  OP_SUB = 8'd7,  OP_MUL = 8'd8,
        OP_DIV = 8'd9,  OP_CMP = 8'd10, OP_JMP = 8'd11, OP_JEQ = 8'd12,
        OP_JNE = 8'd13, OP_JGT = 8'd14, OP_JGE = 8'd15, OP_JLT = 8'd16,
        OP_JLE = 8'd17, OP_HLT = 8'd18
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_OPND, ST_EXEC, ST_HALT
    } step_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV
    } alu_op_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } cmp_t;

    typedef struct packed {
        logic    ir_ld;      // capture opcode byte
        logic    opnd_ld;    // capture operand byte
        logic    pc_inc;     // step program counter by one
        logic    pc_ld;      // load program counter from operand
        logic    a_ld;       // load A from memory
        logic    b_ld;       // load B
        logic    b_imm;      // B source: operand byte instead of memory
        logic    c_ld;       // load C from ALU
        logic    t_ld;       // load compare flags
        logic    addr_opnd;  // address bus: operand instead of PC
        logic    wr_c;       // write data: C instead of B
        alu_op_e alu_op;     // ALU function
    } ctl_t;

    // True for opcodes that are followed by an address or constant byte.
    function automatic logic has_operand(input logic [7:0] op);
        return ((op >= OP_LDA) && (op <= OP_STC)) ||
               ((op >= OP_JMP) && (op <= OP_JLE));
    endfunction

endpackage

// File: rtl/cpu_alu.sv
// Module: cpu_alu
// Combinational arithmetic unit for the C-result instructions.
// Assumes results wrap modulo 2**DATA_W; division by zero yields all ones.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    // Select the arithmetic function named by the sequencer.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;
            ALU_DIV: y = (b == '0) ? '1 : a / b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cpu_ctrl.sv
// Module: cpu_ctrl
// Step sequencer: fetch, decode, optional operand fetch, execute, halt.
// Produces bus strobes and per-register load enables for the datapath.
// Assumes memory read data is valid in the same cycle as mem_rd.
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ir,
    input  cmp_t       flags,
    output ctl_t       ctl,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       halted
);

    step_e step_q, step_d;
    logic  take;

    // Step register, returns to opcode fetch on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_FETCH;
        else        step_q <= step_d;
    end

    // Choose the next step from the current step and opcode length.
    always_comb begin
        unique case (step_q)
            ST_FETCH:  step_d = ST_DECODE;
            ST_DECODE: step_d = has_operand(ir) ? ST_OPND : ST_EXEC;
            ST_OPND:   step_d = ST_EXEC;
            ST_EXEC:   step_d = (ir == OP_HLT) ? ST_HALT : ST_FETCH;
            ST_HALT:   step_d = ST_HALT;
            default:   step_d = ST_FETCH;
        endcase
    end

    // Branch condition against the flags from the last compare.
    always_comb begin
        case (ir)
            OP_JMP:  take = 1'b1;
            OP_JEQ:  take = flags.eq;
            OP_JNE:  take = !flags.eq;
            OP_JGT:  take = flags.gt;
            OP_JGE:  take = flags.gt | flags.eq;
            OP_JLT:  take = flags.lt;
            OP_JLE:  take = flags.lt | flags.eq;
            default: take = 1'b0;
        endcase
    end

    // Decode the current step and opcode into strobes and load enables.
    always_comb begin
        ctl    = '0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        case (step_q)
            ST_FETCH: begin
                mem_rd     = 1'b1;
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_OPND: begin
                mem_rd      = 1'b1;
                ctl.opnd_ld = 1'b1;
                ctl.pc_inc  = 1'b1;
            end
            ST_EXEC: begin
                case (ir)
                    OP_LDA: begin
                        ctl.addr_opnd = 1'b1;
                        mem_rd        = 1'b1;
                        ctl.a_ld      = 1'b1;
                    end
                    OP_LDB: begin
                        ctl.addr_opnd = 1'b1;
                        mem_rd        = 1'b1;
                        ctl.b_ld      = 1'b1;
                    end
                    OP_LDI: begin
                        ctl.b_ld  = 1'b1;
                        ctl.b_imm = 1'b1;
                    end
                    OP_STB: begin
                        ctl.addr_opnd = 1'b1;
                        mem_wr        = 1'b1;
                    end
                    OP_STC: begin
                        ctl.addr_opnd = 1'b1;
                        ctl.wr_c      = 1'b1;
                        mem_wr        = 1'b1;
                    end
                    OP_ADD: begin ctl.c_ld = 1'b1; ctl.alu_op = ALU_ADD; end
                    OP_SUB: begin ctl.c_ld = 1'b1; ctl.alu_op = ALU_SUB; end
                    OP_MUL: begin ctl.c_ld = 1'b1; ctl.alu_op = ALU_MUL; end
                    OP_DIV: begin ctl.c_ld = 1'b1; ctl.alu_op = ALU_DIV; end
                    OP_CMP: ctl.t_ld = 1'b1;
                    OP_JMP, OP_JEQ, OP_JNE, OP_JGT,
                    OP_JGE, OP_JLT, OP_JLE: ctl.pc_ld = take;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    assign halted = (step_q == ST_HALT);

    // R10: one bus direction per cycle.
    a_r10_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: halt is permanent until reset.
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7: no bus traffic while halted.
    a_r7_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R2: every opcode fetch is followed by a decode step.
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_FETCH) |=> (step_q == ST_DECODE));

    // R4: a store strobe lasts one cycle.
    a_r4_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

endmodule

// File: rtl/cpu_datapath.sv
// Module: cpu_datapath
// Program counter, instruction and operand registers, A/B/C and compare
// flags, plus the address and write-data muxes. Every register loads only
// when the sequencer enables it.
// Assumes pc_ld and pc_inc are never requested together.
module cpu_datapath
    import cpu_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [7:0]        ir,
    output cmp_t              flags
);

    logic [DATA_W-1:0] pc_q, opnd_q, a_q, b_q, c_q, alu_y;
    logic [7:0]        ir_q;
    cmp_t              flags_q;

    cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ctl.alu_op),
        .a  (a_q),
        .b  (b_q),
        .y  (alu_y)
    );

    // Program counter: jump load or single-step increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= '0;
        else if (ctl.pc_ld)  pc_q <= opnd_q;
        else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
    end

    // Instruction and operand byte capture from the read bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= '0;
            opnd_q <= '0;
        end else begin
            if (ctl.ir_ld)   ir_q   <= mem_rdata[7:0];
            if (ctl.opnd_ld) opnd_q <= mem_rdata;
        end
    end

    // Working registers and compare flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            c_q     <= '0;
            flags_q <= '0;
        end else begin
            if (ctl.a_ld) a_q <= mem_rdata;
            if (ctl.b_ld) b_q <= ctl.b_imm ? opnd_q : mem_rdata;
            if (ctl.c_ld) c_q <= alu_y;
            if (ctl.t_ld) flags_q <= '{lt: a_q < b_q, gt: a_q > b_q, eq: a_q == b_q};
        end
    end

    assign mem_addr  = ctl.addr_opnd ? opnd_q : pc_q;
    assign mem_wdata = ctl.wr_c ? c_q : b_q;
    assign ir        = ir_q;
    assign flags     = flags_q;

    // R2: each fetch step moves the program counter by exactly one.
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> (pc_q == DATA_W'($past(pc_q) + 1'b1)));

    // R6: a taken branch lands on the operand byte.
    a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_ld |=> (pc_q == $past(opnd_q)));

    // R5: an arithmetic step leaves A and B untouched.
    a_r5_sources_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.c_ld |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/byte_seq_cpu.sv
// Module: byte_seq_cpu
// Top level of the multi-cycle 8-bit core: sequencer plus datapath on a
// single shared memory bus with combinational read data.
// Assumes an external memory that writes on the edge after mem_wr.
module byte_seq_cpu
    import cpu_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    ctl_t       ctl;
    logic [7:0] ir;
    cmp_t       flags;

    cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir     (ir),
        .flags  (flags),
        .ctl    (ctl),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .halted (halted)
    );

    cpu_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ir        (ir),
        .flags     (flags)
    );

endmodule

// File: tb/tb_byte_seq_cpu.sv
// Directed bench: each task assembles a program, runs it to halt and
// checks memory contents, bus activity and clock counts.
module tb_byte_seq_cpu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_rd, mem_wr, halted;

    logic [7:0] ram [256];
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0;

    int n_chk = 0, n_fail = 0;
    int pc_w, exp_cyc, cyc, wr_cnt, clash_cnt = 0;

    always #5 clk = ~clk;

    byte_seq_cpu dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    assign mem_rdata = ram[mem_addr];

    // Bench memory: loader port has priority over core writes.
    always @(posedge clk) begin
        if (ld_en)       ram[ld_addr] <= ld_data;
        else if (mem_wr) ram[mem_addr] <= mem_wdata;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; writes one byte by the next falling edge.
    task automatic poke(input int a, input int d);
        ld_en = 1'b1; ld_addr = 8'(a); ld_data = 8'(d);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic emit1(input int op);
        poke(pc_w, op); pc_w += 1; exp_cyc += 3;
    endtask

    task automatic emit2(input int op, input int arg);
        poke(pc_w, op); poke(pc_w + 1, arg); pc_w += 2; exp_cyc += 4;
    endtask

    // Hold reset, wipe memory, start a new program at address 0.
    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) poke(i, 0);
        pc_w = 0; exp_cyc = 0;
    endtask

    // Release reset and count clocks until halted.
    task automatic run();
        rst_n = 1'b1; cyc = 0; wr_cnt = 0;
        while (!halted && cyc < 3000) begin
            if (mem_wr) wr_cnt++;
            if (mem_rd && mem_wr) clash_cnt++;
            @(negedge clk);
            cyc++;
        end
        check("R7 halt reached", halted, 1);
    endtask

    function automatic int exp_take(int op, int a, int b, bit cmp);
        bit eq, gt, lt;
        eq = cmp && (a == b); gt = cmp && (a > b); lt = cmp && (a < b);
        case (op)
            11: return 1;
            12: return int'(eq);
            13: return int'(!eq);
            14: return int'(gt);
            15: return int'(gt | eq);
            16: return int'(lt);
            default: return int'(lt | eq);
        endcase
    endfunction

    // R1: reset outputs and zeroed registers.
    task automatic t_reset();
        start();
        emit2(5, 8'hB2); emit2(3, 0); emit1(6); emit2(5, 8'hB3); emit1(18);
        poke(8'hB2, 8'h77); poke(8'hB3, 8'h77);
        check("R1 reset addr", mem_addr, 0);
        check("R1 reset rd", mem_rd, 1);
        check("R1 reset wr", mem_wr, 0);
        check("R1 reset halted", halted, 0);
        run();
        check("R1 C reset zero", ram[8'hB2], 0);
        check("R1 A reset zero", ram[8'hB3], 0);
        check("R2 cycles reset prog", cyc, exp_cyc);
    endtask

    // R3 R4 R5: loads, stores and every ALU function.
    task automatic t_alu();
        start();
        poke(8'h90, 200); poke(8'h91, 100); poke(8'h92, 5);
        emit2(1, 8'h90); emit2(2, 8'h91);
        emit1(6); emit2(5, 8'hA0);
        emit1(7); emit2(5, 8'hA1);
        emit1(8); emit2(5, 8'hA2);
        emit1(9); emit2(5, 8'hA3);
        emit2(3, 0); emit1(9); emit2(5, 8'hA4);
        emit2(4, 8'hA5);
        emit2(1, 8'h92); emit2(3, 9); emit1(7); emit2(5, 8'hA6);
        emit1(18);
        run();
        check("R5 add wrap", ram[8'hA0], 44);
        check("R5 sub", ram[8'hA1], 100);
        check("R5 mul low byte", ram[8'hA2], 32);
        check("R5 div", ram[8'hA3], 2);
        check("R5 div by zero", ram[8'hA4], 255);
        check("R3 immediate into B", ram[8'hA5], 0);
        check("R5 sub wrap", ram[8'hA6], 252);
        check("R4 write count", wr_cnt, 7);
        check("R2 cycles alu prog", cyc, exp_cyc);
    endtask

    // R6: one conditional or unconditional jump after an optional compare.
    task automatic t_branch(input int op, input int a, input int b, input bit cmp);
        int tk;
        start();
        emit2(3, a); emit2(4, 8'h90); emit2(1, 8'h90); emit2(3, b);
        if (cmp) emit1(10);
        emit2(op, pc_w + 6);
        emit2(3, 8'h11); emit2(4, 8'hB0);
        emit1(18);
        tk = exp_take(op, a, b, cmp);
        run();
        check($sformatf("R6 op%0d a%0d b%0d cmp%0d path", op, a, b, cmp),
              ram[8'hB0], tk ? 0 : 8'h11);
        check($sformatf("R6 op%0d a%0d b%0d cycles", op, a, b),
              cyc, exp_cyc - (tk ? 8 : 0));
    endtask

    // R8: unknown codes are one-byte no-operations.
    task automatic t_unknown();
        start();
        emit1(0); emit1(19); emit1(255);
        emit2(3, 8'h42); emit2(4, 8'hB1); emit1(18);
        run();
        check("R8 program continues", ram[8'hB1], 8'h42);
        check("R8 cycles", cyc, exp_cyc);
        check("R8 only one write", wr_cnt, 1);
    endtask

    // R9 and R7: factorial loop, then a quiet halt.
    task automatic t_factorial();
        int busy = 0;
        start();
        emit2(3, 1); emit2(4, 128); emit2(4, 129);
        emit2(1, 128); emit2(3, 5); emit1(10); emit2(14, 29);
        emit2(1, 129); emit2(2, 128); emit1(8); emit2(5, 129);
        emit2(1, 128); emit2(3, 1); emit1(6); emit2(5, 128);
        emit2(11, 6); emit1(18);
        run();
        check("R9 factorial", ram[129], 120);
        check("R9 counter", ram[128], 6);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || !halted) busy++;
        end
        check("R7 halted and silent", busy, 0);
    endtask

    initial begin
        int pa [4] = '{3, 2, 9, 200};
        int pb [4] = '{3, 9, 2, 5};
        t_reset();
        t_alu();
        for (int op = 11; op <= 17; op++)
            for (int k = 0; k < 4; k++) t_branch(op, pa[k], pb[k], 1'b1);
        for (int op = 12; op <= 17; op++) t_branch(op, 4, 4, 1'b0);
        t_unknown();
        t_factorial();
        check("R10 no rd/wr overlap", clash_cnt, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failure that still prints the summary.
    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 180000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule